// File: doc/BRIEF.md
# Lookup-Table Dual-Port RAM

A small word-organised RAM whose layout mirrors what a logic-cell lookup table provides when it is used as memory. Each bank holds 16 words of a configurable width. There is one write port, made of a write address, write data and a write enable. Writes are taken on the rising clock edge. The block has two read outputs. The write-side output always shows the word at the write address. The read-side output shows the word at a separate read address, which can only be read.

By default both reads are combinational: each output follows its address with no clock involved. A build-time option places a flip-flop after each read output, which turns both reads into synchronous reads with one cycle of latency. A second option stacks two 16-word banks into a 32-word memory. The extra top address bit picks the bank that takes a write, and it also picks which bank feeds each output. A third option clears the contents and the output flops on reset. Without it, the contents after reset are undefined.

Top module: `lut_dpram`

## Requirements
- R1: With the stacking option off, the memory holds 16 words selected by a 4-bit address. A word is written only on a rising clock edge while `we_i` is 1, and it takes the value of `wdata_i`.
- R2: While `we_i` is 0, a clock edge leaves every word unchanged, whatever `waddr_i` and `wdata_i` carry.
- R3: With the output register off, `wport_rdata_o` equals the stored word at `waddr_i`. It follows a change of `waddr_i` within the same cycle, with no clock edge in between.
- R4: With the output register off, `rport_rdata_o` equals the stored word at `raddr_i`, which is independent of `waddr_i`. It also follows its address within the same cycle.
- R5: When a write targets the address that an unregistered output is showing, that output carries the new word immediately after the writing edge.
- R6: With the output register on, each output shows the word that was stored at its address just before the previous rising edge. A word written at edge k therefore appears on that address's output after edge k+1.
- R7: With the stacking option on, addresses are 5 bits wide. Address bit 4 selects bank 0 (value 0) or bank 1 (value 1) for a write, and the same bit selects the bank for each read. Addresses that differ only in bit 4 hold separate words.
- R8: All `DATA_W` bits of a word share one address and one write enable, and each bit is stored and returned independently of the others.
- R9: With clear-on-reset on, asserting `rst_ni` low sets every word and every output flop to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock; also clocks the optional output flops |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write enable |
| waddr_i | input | ADDR_W (4, or 5 when stacked) | Write address; also the address of the write-side read output |
| wdata_i | input | DATA_W | Write data |
| raddr_i | input | ADDR_W | Address for the read-only output |
| wport_rdata_o | output | DATA_W | Word at the write address |
| rport_rdata_o | output | DATA_W | Word at the read-only address |

## Verification
Two cases are hard to reach from the ports. The first is a write and a read hitting the same word in the same cycle. The second is pairs of stacked addresses that differ only in the bank bit. The stimulus sweeps every address with a data pattern that is a function of the address, and it points the read address at a shifted position so that the two outputs are never trivially equal. A final sweep then sets the read and write addresses equal during each write. This sweep checks the combinational output before and after the edge, and the registered output one edge later. It runs on two builds at once: one with 16 words and unregistered reads, and one with 32 stacked words and registered reads.

// File: rtl/lut_dpram_pkg.sv
package lut_dpram_pkg;
  localparam int unsigned BANK_AW    = 4;
  localparam int unsigned BANK_DEPTH = 1 << BANK_AW;
endpackage

// File: rtl/lut_bank.sv
module lut_bank
  import lut_dpram_pkg::*;
#(
  parameter int unsigned DATA_W       = 4,
  parameter bit          CLEAR_ON_RST = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [BANK_AW-1:0] waddr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [BANK_AW-1:0] raddr_i,
  output logic [DATA_W-1:0]  wrd_o,
  output logic [DATA_W-1:0]  rrd_o
);
  logic [DATA_W-1:0] mem_q [BANK_DEPTH];

  if (CLEAR_ON_RST) begin : g_clr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < BANK_DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
        mem_q[waddr_i] <= wdata_i;
      end
    end
  end else begin : g_noclr
    always_ff @(posedge clk_i) begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
    end
  end

  // asynchronous reads
  assign wrd_o = mem_q[waddr_i];
  assign rrd_o = mem_q[raddr_i];

  // R1: an enabled edge stores the presented word
  a_r1_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

  // R2: no enable, same address -> read word unchanged
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i ##1 (waddr_i == $past(waddr_i)) |-> wrd_o == $past(wrd_o));
endmodule

// File: rtl/lut_rd_stage.sv
module lut_rd_stage #(
  parameter int unsigned DATA_W       = 4,
  parameter bit          OUT_REG      = 1'b0,
  parameter bit          CLEAR_ON_RST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  if (OUT_REG) begin : g_reg
    logic [DATA_W-1:0] q_q;
    if (CLEAR_ON_RST) begin : g_clr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= d_i;
      end
    end else begin : g_noclr
      always_ff @(posedge clk_i) q_q <= d_i;
    end
    assign q_o = q_q;
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/lut_dpram.sv
module lut_dpram
  import lut_dpram_pkg::*;
#(
  parameter int unsigned DATA_W       = 4,
  parameter bit          STACK2       = 1'b0,
  parameter bit          OUT_REG      = 1'b0,
  parameter bit          CLEAR_ON_RST = 1'b1,
  localparam int unsigned ADDR_W      = STACK2 ? BANK_AW + 1 : BANK_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] wport_rdata_o,
  output logic [DATA_W-1:0] rport_rdata_o
);
  logic [DATA_W-1:0] wrd_mux, rrd_mux;

  if (STACK2) begin : g_stack
    logic [1:0]        bank_we;
    logic [DATA_W-1:0] wrd_b [2];
    logic [DATA_W-1:0] rrd_b [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
      assign bank_we[b] = we_i && (waddr_i[ADDR_W-1] == 1'(b));
      lut_bank #(.DATA_W(DATA_W), .CLEAR_ON_RST(CLEAR_ON_RST)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (bank_we[b]),
        .waddr_i (waddr_i[BANK_AW-1:0]),
        .wdata_i (wdata_i),
        .raddr_i (raddr_i[BANK_AW-1:0]),
        .wrd_o   (wrd_b[b]),
        .rrd_o   (rrd_b[b])
      );
    end

    assign wrd_mux = wrd_b[waddr_i[ADDR_W-1]];
    assign rrd_mux = rrd_b[raddr_i[ADDR_W-1]];

    // R7: at most one bank takes a write
    a_r7_bank_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(bank_we) && (we_i -> (bank_we != 2'b00)));
  end else begin : g_single
    lut_bank #(.DATA_W(DATA_W), .CLEAR_ON_RST(CLEAR_ON_RST)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_i),
      .waddr_i (waddr_i),
      .wdata_i (wdata_i),
      .raddr_i (raddr_i),
      .wrd_o   (wrd_mux),
      .rrd_o   (rrd_mux)
    );
  end

  lut_rd_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG), .CLEAR_ON_RST(CLEAR_ON_RST)) u_wstage (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (wrd_mux), .q_o (wport_rdata_o)
  );
  lut_rd_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG), .CLEAR_ON_RST(CLEAR_ON_RST)) u_rstage (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (rrd_mux), .q_o (rport_rdata_o)
  );

  if (OUT_REG) begin : g_chk_reg
    // R6: written word reaches the output one edge after the write
    a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i ##1 (waddr_i == $past(waddr_i)) ##1 (waddr_i == $past(waddr_i))
        |-> wport_rdata_o == $past(wdata_i, 2));
  end else begin : g_chk_comb
    // R5: written word visible right after the edge
    a_r5_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i ##1 (waddr_i == $past(waddr_i)) |-> wport_rdata_o == $past(wdata_i));
  end
endmodule

// File: tb/lut_dpram_tb.sv
module lut_dpram_tb_top;
  localparam int CLK_P = 10;
  localparam int DW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we_s = 1'b0;
  logic [4:0]    wa_s = '0, ra_s = '0;
  logic [DW-1:0] wd_s = '0;
  logic [DW-1:0] a_o, b_o, ca_o, cb_o;

  logic [DW-1:0] ref1 [16];
  logic [DW-1:0] ref2 [32];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lut_dpram #(.DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we_s), .waddr_i(wa_s[3:0]), .wdata_i(wd_s),
    .raddr_i(ra_s[3:0]), .wport_rdata_o(a_o), .rport_rdata_o(b_o)
  );

  lut_dpram #(.DATA_W(DW), .STACK2(1'b1), .OUT_REG(1'b1)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we_s), .waddr_i(wa_s), .wdata_i(wd_s),
    .raddr_i(ra_s), .wport_rdata_o(ca_o), .rport_rdata_o(cb_o)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 5 + 3 + salt) ^ (a >> 2));
  endfunction

  // one cycle: inputs applied at falling edge, checks before and after the rising edge
  task automatic cyc(input logic we, input logic [4:0] wa, input logic [4:0] ra,
                     input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] ea, eb;
    we_s = we; wa_s = wa; ra_s = ra; wd_s = d;
    #1;
    chk("R3 port A follows address before edge", a_o, ref1[wa[3:0]]);
    chk("R4 port B follows address before edge", b_o, ref1[ra[3:0]]);
    ea = ref2[wa];
    eb = ref2[ra];
    if (we) begin
      ref1[wa[3:0]] = d;
      ref2[wa]      = d;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " port A"}, a_o, ref1[wa[3:0]]);
    chk({tag, " port B"}, b_o, ref1[ra[3:0]]);
    chk("R6/R7 registered stacked port A", ca_o, ea);
    chk("R6/R7 registered stacked port B", cb_o, eb);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) ref1[i] = '0;
    for (int i = 0; i < 32; i++) ref2[i] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset port A", a_o, '0);
    chk("R9 reset port B", b_o, '0);
    chk("R9 reset reg port A", ca_o, '0);
    chk("R9 reset reg port B", cb_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R8: fill every address with an address-derived pattern
    for (int a = 0; a < 32; a++)
      cyc(1'b1, 5'(a), 5'((a + 7) % 32), pat(a, 0), "R1/R8 write sweep");

    // R2: disabled writes must not disturb anything
    for (int a = 0; a < 32; a++)
      cyc(1'b0, 5'(a), 5'((a + 11) % 32), ~pat(a, 0), "R2 disabled write");

    // R4/R7: read-only port sweeps all addresses against fixed write address
    for (int a = 0; a < 32; a++)
      cyc(1'b0, 5'd21, 5'(a), '0, "R4/R7 read sweep");

    // R5/R6: write and read the same word in one cycle
    for (int a = 0; a < 32; a++) begin
      cyc(1'b1, 5'(a), 5'(a), pat(a, 9), "R5 same-address write");
      cyc(1'b0, 5'(a), 5'(a), '1, "R5/R6 follow-up");
    end

    // R7: bank bit separates aliasing pairs
    for (int a = 0; a < 16; a++) begin
      cyc(1'b1, 5'(a + 16), 5'(a), pat(a, 4), "R7 upper bank write");
      cyc(1'b0, 5'(a), 5'(a + 16), '0, "R7 alias read");
    end

    // R8: walking single-bit and all-ones words
    for (int b = 0; b < DW; b++)
      cyc(1'b1, 5'(b + 2), 5'(b + 2), DW'(1 << b), "R8 single bit");
    cyc(1'b1, 5'd31, 5'd2, '1, "R8 all ones");
    cyc(1'b0, 5'd31, 5'd3, '0, "R8 readback");

    // R9: reset mid-run clears contents
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 clear port A", a_o, '0);
    chk("R9 clear reg port B", cb_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) ref1[i] = '0;
    for (int i = 0; i < 32; i++) ref2[i] = '0;
    for (int a = 0; a < 32; a += 5)
      cyc(1'b0, 5'(a), 5'(31 - a), '0, "R9 cleared contents");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule